// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Register Block

This block sits beside a DRAM datapath that is protected by a single-error-correct, double-error-detect code over 64-bit words. The ECC checker reports two kinds of event: correctable (one bit flipped and repaired) and uncorrectable (two bits flipped, detected only). Each event carries the failing address, the 8-bit syndrome and the 64-bit word that was read. The block latches each class into its own set of capture registers, records the event in an interrupt status register and drives a level interrupt toward the processor. Software reads the status and the captured details over a simple APB-style register port, then clears the status by writing the bits it wants cleared to an acknowledge offset.

A second event of a class that arrives while the first is still pending does not overwrite the capture. It only sets a "second event" flag, so software always sees the oldest failure in full. The block also holds an option register. It selects the ECC mode, and it can arm a one-shot error injection: the next write issued to DRAM has a software-chosen 8-bit pattern XORed into its check bits, which lets diagnostics force a known error.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `chk_xor` is zero.
- R2: The status register (offset 0x004) holds the correctable flag at bit 3, the second-correctable flag at bit 4, the uncorrectable flag at bit 5 and the second-uncorrectable flag at bit 6. All other bits read zero. The enable register (offset 0x00C) uses the same bit positions.
- R3: When ECC is on and no correctable flag is pending, a `ce_evt` pulse sets bit 3. It also captures the address at 0x010, the syndrome in bits 15:8 of 0x014, data bits 31:0 at 0x018 and data bits 63:32 at 0x01C.
- R4: Under the same conditions an uncorrectable event sets bit 5 and captures into its own set: address at 0x020, syndrome in bits 15:8 of 0x024, and the low and high data halves at 0x028 and 0x02C.
- R5: An event of a class whose first flag is already pending sets that class's second-event flag and leaves the captured address, syndrome and data unchanged.
- R6: A correctable and an uncorrectable event in the same cycle are both captured in their own registers, and both flags are set.
- R7: A write to the acknowledge offset (0x008) clears exactly the status bits that are one in the written value. An event that arrives in the same cycle as the acknowledge of its own first flag is captured as a fresh first event.
- R8: `irq` is high exactly when some status bit is set whose enable bit is also set. It drops once no enabled status bit remains.
- R9: The option register (offset 0x000) holds the mode in bits 1:0. In modes 0 and 2 ECC is off and events are ignored. In modes 1 and 3 they are captured.
- R10: While option bit 8 is set, `chk_xor` presents option bits 23:16. Bit 8 clears itself in the cycle after `wr_issue` is seen, so one arming affects exactly one write.
- R11: Reads of the option register return the mode, arm bit and pattern at their positions, with all other bits zero. The acknowledge offset and undefined offsets read zero. Writes to undefined or read-only offsets change nothing.
- R12: Register accesses take effect in the APB access phase (`psel` and `penable` both high). Read data is valid during that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ce_evt | input | 1 | Correctable event pulse |
| ce_addr | input | 32 | Correctable failing address |
| ce_syn | input | 8 | Correctable syndrome |
| ce_data | input | 64 | Correctable read word |
| ue_evt | input | 1 | Uncorrectable event pulse |
| ue_addr | input | 32 | Uncorrectable failing address |
| ue_syn | input | 8 | Uncorrectable syndrome |
| ue_data | input | 64 | Uncorrectable read word |
| wr_issue | input | 1 | A DRAM write is issued this cycle |
| chk_xor | output | 8 | Pattern to XOR into check bits of the write |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that event pulses last one cycle each, that `wr_issue` marks single write commands, and that register accesses follow the two-phase APB order with `psel` held through the access phase. The hold property for captured fields assumes that software does not acknowledge and raise a new event of the same class in an unplanned way. The stimulus keeps to these rules: every access comes from one task with a fixed setup and access phase, and every event comes from a pulse task. The only overlap of acknowledge and event is placed deliberately, to exercise the fresh-capture rule.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

    // Error classes, one capture bank each
    localparam int NUM_CLASS = 2;
    localparam int CLS_CORR  = 0;
    localparam int CLS_UNCOR = 1;

    // Status flags start here; class c uses bits FLAG_LSB+2c (first) and +1 (second)
    localparam int FLAG_LSB  = 3;
    localparam int NUM_FLAGS = 2 * NUM_CLASS;

    // Option register fields
    localparam int OPT_MODE_LSB = 0;
    localparam int OPT_ARM_BIT  = 8;
    localparam int OPT_PAT_LSB  = 16;

    // Byte offsets
    localparam int OFS_OPT     = 'h000;
    localparam int OFS_STAT    = 'h004;
    localparam int OFS_ACK     = 'h008;
    localparam int OFS_EN      = 'h00C;
    localparam int OFS_CAP0    = 'h010;
    localparam int CAP_STRIDE  = 'h010;
    localparam int CAP_ADDR    = 'h0;
    localparam int CAP_SYN     = 'h4;
    localparam int CAP_DLO     = 'h8;
    localparam int CAP_DHI     = 'hC;
    localparam int SYN_SHIFT   = 8;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_ON_LO  = 2'd1,
        MODE_OFF    = 2'd2,
        MODE_ON_HI  = 2'd3
    } ecc_mode_e;

    function automatic logic mode_active(input ecc_mode_e m);
        return (m == MODE_ON_LO) || (m == MODE_ON_HI);
    endfunction

endpackage

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_on,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [SYN_W-1:0]  evt_syn,
    input  logic [DATA_W-1:0] evt_data,
    input  logic              clr_first,
    input  logic              clr_second,
    output logic              first_o,
    output logic              second_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SYN_W-1:0]  syn_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              first;
        logic              second;
        logic [ADDR_W-1:0] addr;
        logic [SYN_W-1:0]  syn;
        logic [DATA_W-1:0] data;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  still_pending;

    always_comb begin
        bank_d        = bank_q;
        still_pending = bank_q.first && !clr_first;
        if (clr_first)  bank_d.first  = 1'b0;
        if (clr_second) bank_d.second = 1'b0;
        if (ecc_on && evt) begin
            if (still_pending) begin
                bank_d.second = 1'b1;
            end else begin
                bank_d.first = 1'b1;
                bank_d.addr  = evt_addr;
                bank_d.syn   = evt_syn;
                bank_d.data  = evt_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign first_o  = bank_q.first;
    assign second_o = bank_q.second;
    assign addr_o   = bank_q.addr;
    assign syn_o    = bank_q.syn;
    assign data_o   = bank_q.data;

    // R5: a pending capture is never overwritten
    p_hold_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_o && !clr_first) |=> ($stable(addr_o) && $stable(syn_o) && $stable(data_o)))
        else $error("capture overwritten while pending");

    // R3 / R4: a fresh event with ECC on raises the first flag
    p_capture_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_on && evt && !first_o) |=> first_o)
        else $error("event not flagged");

    // R9: with ECC off and no acknowledge, flags do not move
    p_mode_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_on && !clr_first && !clr_second) |=> ($stable(first_o) && $stable(second_o)))
        else $error("flag changed while ECC off");

endmodule

// File: rtl/ecc_opt_ctl.sv
module ecc_opt_ctl
    import ecc_err_pkg::*;
#(
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             wr_issue,
    output ecc_mode_e        mode_o,
    output logic             arm_o,
    output logic [SYN_W-1:0] pat_o,
    output logic [SYN_W-1:0] chk_xor_o
);

    typedef struct packed {
        ecc_mode_e        mode;
        logic             arm;
        logic [SYN_W-1:0] pat;
    } opt_t;

    opt_t opt_d, opt_q;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^wdata;

    always_comb begin
        opt_d = opt_q;
        if (wr_en) begin
            opt_d.mode = ecc_mode_e'(wdata[OPT_MODE_LSB +: 2]);
            opt_d.arm  = wdata[OPT_ARM_BIT];
            opt_d.pat  = wdata[OPT_PAT_LSB +: SYN_W];
        end else if (wr_issue && opt_q.arm) begin
            opt_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) opt_q <= '0;
        else        opt_q <= opt_d;
    end

    assign mode_o    = opt_q.mode;
    assign arm_o     = opt_q.arm;
    assign pat_o     = opt_q.pat;
    assign chk_xor_o = opt_q.arm ? opt_q.pat : '0;

    // R10: one injected write per arming
    p_inject_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && arm_o && !wr_en) |=> !arm_o)
        else $error("injection stayed armed after write");

    // R10: arming only comes from software
    p_arm_from_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_o) |-> $past(wr_en))
        else $error("arm bit set without register write");

endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
    import ecc_err_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SYN_W   = 8,
    parameter int DATA_W  = 64,
    parameter int PADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    input  logic               ce_evt,
    input  logic [ADDR_W-1:0]  ce_addr,
    input  logic [SYN_W-1:0]   ce_syn,
    input  logic [DATA_W-1:0]  ce_data,
    input  logic               ue_evt,
    input  logic [ADDR_W-1:0]  ue_addr,
    input  logic [SYN_W-1:0]   ue_syn,
    input  logic [DATA_W-1:0]  ue_data,
    input  logic               wr_issue,
    output logic [SYN_W-1:0]   chk_xor,
    output logic               irq
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] en;
    } top_t;

    top_t top_d, top_q;

    logic                 acc_wr, opt_wr, ack_wr, en_wr;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_CLASS-1:0] evt_v;
    logic [ADDR_W-1:0]    evt_addr [NUM_CLASS];
    logic [SYN_W-1:0]     evt_syn  [NUM_CLASS];
    logic [DATA_W-1:0]    evt_data [NUM_CLASS];
    logic [ADDR_W-1:0]    cap_addr [NUM_CLASS];
    logic [SYN_W-1:0]     cap_syn  [NUM_CLASS];
    logic [DATA_W-1:0]    cap_data [NUM_CLASS];
    ecc_mode_e            mode;
    logic                 arm;
    logic [SYN_W-1:0]     pat;
    logic                 ecc_on;

    // Register write decode (access phase)
    assign acc_wr = psel && penable && pwrite;
    assign opt_wr = acc_wr && (paddr == PADDR_W'(OFS_OPT));
    assign ack_wr = acc_wr && (paddr == PADDR_W'(OFS_ACK));
    assign en_wr  = acc_wr && (paddr == PADDR_W'(OFS_EN));
    assign clr_v  = ack_wr ? pwdata[FLAG_LSB +: NUM_FLAGS] : '0;

    always_comb begin
        top_d = top_q;
        if (en_wr) top_d.en = pwdata[FLAG_LSB +: NUM_FLAGS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    // Event routing into class-indexed arrays
    assign evt_v               = {ue_evt, ce_evt};
    assign evt_addr[CLS_CORR]  = ce_addr;
    assign evt_addr[CLS_UNCOR] = ue_addr;
    assign evt_syn[CLS_CORR]   = ce_syn;
    assign evt_syn[CLS_UNCOR]  = ue_syn;
    assign evt_data[CLS_CORR]  = ce_data;
    assign evt_data[CLS_UNCOR] = ue_data;

    ecc_opt_ctl #(.SYN_W(SYN_W)) u_opt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (opt_wr),
        .wdata     (pwdata),
        .wr_issue  (wr_issue),
        .mode_o    (mode),
        .arm_o     (arm),
        .pat_o     (pat),
        .chk_xor_o (chk_xor)
    );

    assign ecc_on = mode_active(mode);

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_bank
        ecc_capture_bank #(
            .ADDR_W (ADDR_W),
            .SYN_W  (SYN_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .ecc_on     (ecc_on),
            .evt        (evt_v[c]),
            .evt_addr   (evt_addr[c]),
            .evt_syn    (evt_syn[c]),
            .evt_data   (evt_data[c]),
            .clr_first  (clr_v[2*c]),
            .clr_second (clr_v[2*c+1]),
            .first_o    (flags[2*c]),
            .second_o   (flags[2*c+1]),
            .addr_o     (cap_addr[c]),
            .syn_o      (cap_syn[c]),
            .data_o     (cap_data[c])
        );
    end

    assign irq = |(flags & top_q.en);

    // Read mux
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (paddr == PADDR_W'(OFS_OPT)) begin
                prdata[OPT_MODE_LSB +: 2]    = mode;
                prdata[OPT_ARM_BIT]          = arm;
                prdata[OPT_PAT_LSB +: SYN_W] = pat;
            end else if (paddr == PADDR_W'(OFS_STAT)) begin
                prdata[FLAG_LSB +: NUM_FLAGS] = flags;
            end else if (paddr == PADDR_W'(OFS_EN)) begin
                prdata[FLAG_LSB +: NUM_FLAGS] = top_q.en;
            end
            for (int c = 0; c < NUM_CLASS; c++) begin
                if (paddr == PADDR_W'(OFS_CAP0 + c*CAP_STRIDE + CAP_ADDR))
                    prdata = 32'(cap_addr[c]);
                if (paddr == PADDR_W'(OFS_CAP0 + c*CAP_STRIDE + CAP_SYN))
                    prdata = 32'(cap_syn[c]) << SYN_SHIFT;
                if (paddr == PADDR_W'(OFS_CAP0 + c*CAP_STRIDE + CAP_DLO))
                    prdata = 32'(cap_data[c][HALF_W-1:0]);
                if (paddr == PADDR_W'(OFS_CAP0 + c*CAP_STRIDE + CAP_DHI))
                    prdata = 32'(cap_data[c][DATA_W-1:HALF_W]);
            end
        end
    end

    // R7 / R8: acknowledging every enabled pending bit, with no new event, drops irq
    p_ack_drops_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !ce_evt && !ue_evt &&
         ((flags & ~pwdata[FLAG_LSB +: NUM_FLAGS] & top_q.en) == '0)) |=> !irq)
        else $error("irq still high after full acknowledge");

    // R11: writes elsewhere leave the enable mask alone
    p_en_only_by_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> ($stable(top_q.en)))
        else $error("enable mask changed without its write");

endmodule

// File: tb/tb_ecc_err_regs.sv
module tb_ecc_err_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        ce_evt = 0, ue_evt = 0;
    logic [31:0] ce_addr = '0, ue_addr = '0;
    logic [7:0]  ce_syn = '0, ue_syn = '0;
    logic [63:0] ce_data = '0, ue_data = '0;
    logic        wr_issue = 0;
    logic [7:0]  chk_xor;
    logic        irq;
    logic        probe = 0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    typedef struct {
        int          kind;   // 0 = read data, 1 = irq, 2 = chk_xor
        logic [31:0] exp;
        int          req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    ecc_err_regs dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ce_evt(ce_evt), .ce_addr(ce_addr), .ce_syn(ce_syn), .ce_data(ce_data),
        .ue_evt(ue_evt), .ue_addr(ue_addr), .ue_syn(ue_syn), .ue_data(ue_data),
        .wr_issue(wr_issue), .chk_xor(chk_xor), .irq(irq)
    );

    // Monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        item_t it;
        logic [31:0] obs;
        if (rst_n && ((psel && penable && !pwrite) || probe)) begin
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R0 scoreboard empty: actual %08h expected none", prdata);
            end else begin
                it  = sb.pop_front();
                obs = (it.kind == 0) ? prdata : (it.kind == 1) ? {31'b0, irq} : {24'b0, chk_xor};
                n_cmp++;
                if (obs !== it.exp) begin
                    n_bad++;
                    $display("FAIL R%0d kind %0d: actual %08h expected %08h", it.req, it.kind, obs, it.exp);
                end
            end
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(posedge clk); #1 penable = 1;
        @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [11:0] a, input logic [31:0] e, input int req);
        sb.push_back('{0, e, req});
        @(posedge clk); #1;
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(posedge clk); #1 penable = 1;
        @(posedge clk); #1 psel = 0; penable = 0;
    endtask

    task automatic probe_chk(input int kind, input logic [31:0] e, input int req);
        sb.push_back('{kind, e, req});
        @(posedge clk); #1 probe = 1;
        @(posedge clk); #1 probe = 0;
    endtask

    task automatic pulse_evt(input bit c, input bit u,
                             input logic [31:0] ca, input logic [7:0] cs, input logic [63:0] cd,
                             input logic [31:0] ua, input logic [7:0] us, input logic [63:0] ud);
        @(posedge clk); #1;
        ce_evt = c; ce_addr = ca; ce_syn = cs; ce_data = cd;
        ue_evt = u; ue_addr = ua; ue_syn = us; ue_data = ud;
        @(posedge clk); #1 ce_evt = 0; ue_evt = 0;
    endtask

    task automatic pulse_wr;
        @(posedge clk); #1 wr_issue = 1;
        @(posedge clk); #1 wr_issue = 0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R0 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset values
        apb_read(12'h000, 32'h0, 1);
        apb_read(12'h004, 32'h0, 1);
        apb_read(12'h00C, 32'h0, 1);
        apb_read(12'h010, 32'h0, 1);
        apb_read(12'h02C, 32'h0, 1);
        probe_chk(1, 32'h0, 1);
        probe_chk(2, 32'h0, 1);

        // R11: undefined and read-only writes are ignored, ack reads zero
        apb_write(12'h040, 32'hFFFF_FFFF);
        apb_write(12'h004, 32'hFFFF_FFFF);
        apb_write(12'h014, 32'hFFFF_FFFF);
        apb_read(12'h040, 32'h0, 11);
        apb_read(12'h004, 32'h0, 11);
        apb_read(12'h014, 32'h0, 11);
        apb_read(12'h008, 32'h0, 11);
        apb_read(12'h000, 32'h0, 11);

        // R9: mode 0 and mode 2 ignore events
        pulse_evt(1, 1, 32'h1111_0000, 8'h11, 64'h1, 32'h2222_0000, 8'h22, 64'h2);
        apb_read(12'h004, 32'h0, 9);
        apb_write(12'h000, 32'h0000_0002);
        pulse_evt(1, 1, 32'h1111_0000, 8'h11, 64'h1, 32'h2222_0000, 8'h22, 64'h2);
        apb_read(12'h004, 32'h0, 9);
        apb_read(12'h010, 32'h0, 9);
        apb_read(12'h020, 32'h0, 9);

        // R9 / R3: mode 1 captures; R8: enable mask is zero, so irq stays low
        apb_write(12'h000, 32'h0000_0001);
        pulse_evt(1, 0, 32'hA000_1238, 8'h5A, 64'h0123_4567_89AB_CDEF, '0, '0, '0);
        apb_read(12'h004, 32'h0000_0008, 3);   // R2 bit 3
        probe_chk(1, 32'h0, 8);
        apb_write(12'h00C, 32'h0000_0078);
        apb_read(12'h00C, 32'h0000_0078, 2);
        probe_chk(1, 32'h1, 8);
        apb_read(12'h010, 32'hA000_1238, 3);
        apb_read(12'h014, 32'h0000_5A00, 3);
        apb_read(12'h018, 32'h89AB_CDEF, 3);
        apb_read(12'h01C, 32'h0123_4567, 3);

        // R5: second correctable event only sets bit 4
        pulse_evt(1, 0, 32'hBEEF_0000, 8'hC3, 64'hFFFF_0000_FFFF_0000, '0, '0, '0);
        apb_read(12'h004, 32'h0000_0018, 5);
        apb_read(12'h010, 32'hA000_1238, 5);
        apb_read(12'h014, 32'h0000_5A00, 5);
        apb_read(12'h018, 32'h89AB_CDEF, 5);

        // R7: ack clears only written bits; R8: irq follows
        apb_write(12'h008, 32'h0000_0008);
        apb_read(12'h004, 32'h0000_0010, 7);
        probe_chk(1, 32'h1, 8);
        apb_write(12'h008, 32'h0000_0010);
        apb_read(12'h004, 32'h0, 7);
        probe_chk(1, 32'h0, 7);

        // R6 / R4: same-cycle events in mode 3
        apb_write(12'h000, 32'h0000_0003);
        pulse_evt(1, 1, 32'hC0DE_0040, 8'h0F, 64'h1122_3344_5566_7788,
                        32'hDEAD_0080, 8'hE1, 64'h99AA_BBCC_DDEE_F001);
        apb_read(12'h004, 32'h0000_0028, 6);
        apb_read(12'h010, 32'hC0DE_0040, 6);
        apb_read(12'h020, 32'hDEAD_0080, 4);
        apb_read(12'h024, 32'h0000_E100, 4);
        apb_read(12'h028, 32'hDDEE_F001, 4);
        apb_read(12'h02C, 32'h99AA_BBCC, 4);
        probe_chk(1, 32'h1, 8);

        // R7: ack of CE first flag in the same cycle as a new CE event
        fork
            apb_write(12'h008, 32'h0000_0008);
            begin
                @(posedge clk); @(posedge clk); #1;
                ce_evt = 1; ce_addr = 32'h7777_0008; ce_syn = 8'h3C; ce_data = 64'h5;
                @(posedge clk); #1 ce_evt = 0;
            end
        join
        apb_read(12'h004, 32'h0000_0028, 7);
        apb_read(12'h010, 32'h7777_0008, 7);
        apb_read(12'h014, 32'h0000_3C00, 7);

        // R8: UE-only enable, clear CE; irq stays from UE, then drops
        apb_write(12'h00C, 32'h0000_0020);
        apb_write(12'h008, 32'h0000_0008);
        probe_chk(1, 32'h1, 8);
        apb_write(12'h008, 32'h0000_0020);
        probe_chk(1, 32'h0, 8);
        apb_read(12'h004, 32'h0, 2);

        // R10: one-shot injection
        apb_write(12'h000, 32'h00A5_0101);
        apb_read(12'h000, 32'h00A5_0101, 11);
        probe_chk(2, 32'h0000_00A5, 10);
        probe_chk(2, 32'h0000_00A5, 10);
        pulse_wr();
        probe_chk(2, 32'h0, 10);
        apb_read(12'h000, 32'h00A5_0001, 10);
        pulse_wr();
        probe_chk(2, 32'h0, 10);

        // R12: setup phase alone does not write
        @(posedge clk); #1;
        psel = 1; pwrite = 1; penable = 0; paddr = 12'h00C; pwdata = 32'h0000_0078;
        @(posedge clk); #1 psel = 0; pwrite = 0;
        apb_read(12'h00C, 32'h0000_0020, 12);

        repeat (4) @(posedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R0 leftover items: actual %0d expected 0", sb.size());
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule